// File: doc/BRIEF.md
# Extended Multiblock Sync Tracker

This block sits behind a sync header aligner on one receive lane of a 64b/66b style serial link. Once the aligner reports header lock, it hands over one sync transition bit per received block, qualified by a valid strobe. The tracker treats every 32 consecutive transition bits as the sync word of a multiblock, with the first received bit as bit 0. It hunts for the marker that closes an extended multiblock, then follows the multiblock and extended multiblock boundaries. After enough consecutive good boundaries it declares extended multiblock lock.

An extended multiblock holds E multiblocks. E is a runtime input, normally computed as LCM(F,256)/256 from the octets per frame F. Downstream logic, such as a lane deskew buffer, uses the end-of-multiblock and end-of-extended-multiblock strobes and the block index to find block positions. The remaining fields of the sync word (error check bits and the command channel) are left to other logic.

Top module: `emb_sync_tracker`

## Requirements
- R1: While rst_n is low and right after reset, emb_lock, eomb_stb and eoemb_stb are 0 and blk_idx is 0.
- R2: Before alignment, strobes stay low and blk_idx stays 0. Alignment is taken on the accepted bit that completes the arrival-order sequence 1,0,0,0,0,1. That block reports blk_idx 31 with both strobes high.
- R3: Once aligned, each accepted bit advances blk_idx by one, wrapping from 31 to 0. eomb_stb pulses only at blk_idx 31. All three outputs are registered and are valid in the cycle after the clock edge that accepts the bit.
- R4: eoemb_stb pulses at the last block of every E-th multiblock, counted from the alignment point. It always coincides with eomb_stb. An emb_count value of 0 is treated as E = 1.
- R5: At a multiblock end that is not an extended multiblock end, the last five received bits must be 0,0,0,0,1. Otherwise the tracker drops emb_lock, returns to the hunt, gives no strobe and shows blk_idx 0.
- R6: At an extended multiblock end, the last six received bits must be 1,0,0,0,0,1. Otherwise the same loss as in R5 follows.
- R7: emb_lock rises together with the fourth consecutive good extended multiblock end, with the alignment block counted as the first. It then stays high until a loss or a header lock drop.
- R8: A cycle with bit_vld low changes no state: the strobes are low, and blk_idx and emb_lock hold.
- R9: When sh_lock goes low, emb_lock is low in the same cycle. At the next edge all tracking state clears, so blk_idx is 0 and the strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| sh_lock | input | 1 | Sync header lock from the header aligner |
| bit_vld | input | 1 | One transition bit is presented this cycle |
| sync_bit | input | 1 | Decoded sync transition bit of the current block |
| emb_count | input | E_W | Multiblocks per extended multiblock (0 acts as 1) |
| emb_lock | output | 1 | Extended multiblock lock |
| eomb_stb | output | 1 | Pulse marking the last block of a multiblock |
| eoemb_stb | output | 1 | Pulse marking the last block of an extended multiblock |
| blk_idx | output | 5 | Index of the most recently accepted block within its multiblock |

## Verification
Each accepted bit passes through one register stage before it appears on blk_idx, eomb_stb, eoemb_stb and emb_lock. The outputs for a bit are therefore due in the cycle after the rising edge that accepts it. The one exception is the emb_lock drop on a falling sh_lock, which must appear in the same cycle, before any edge. The bench drives each bit on a falling edge and compares all four outputs a quarter period after the following rising edge. It checks the lock drop a moment after sh_lock falls, and checks the cleared state again after the next edge. A positional model in the bench tracks where each block sits in the transmitted stream and which multiblocks were corrupted. From that it derives the expected index, strobes and lock for every bit and every idle cycle, for several E values, start phases and corruption points.

// File: rtl/emb_sync_pkg.sv
package emb_sync_pkg;

  localparam int BLK_PER_MB = 32;
  localparam int BLK_W      = $clog2(BLK_PER_MB);

  // Marker closing an extended multiblock, oldest bit in the MSB.
  localparam int          EOEMB_W   = 6;
  localparam logic [5:0]  EOEMB_PAT = 6'b100001;

  // Pilot closing every multiblock, oldest bit in the MSB.
  localparam int          PILOT_W   = 5;
  localparam logic [4:0]  PILOT_PAT = 5'b00001;

  typedef enum logic [1:0] {
    TRK_HUNT  = 2'd0,
    TRK_ALIGN = 2'd1,
    TRK_LOCK  = 2'd2
  } trk_state_t;

endpackage

// File: rtl/emb_sync_hist.sv
module emb_sync_hist
  import emb_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift_en,
  input  logic bit_in,
  output logic eoemb_hit,
  output logic pilot_hit
);

  localparam int HIST_W = EOEMB_W - 1;

  logic [HIST_W-1:0]  hist_q;
  logic [HIST_W-1:0]  hist_d;
  logic [EOEMB_W-1:0] win;

  // Window of the last six bits, including the one presented now.
  assign win = {hist_q, bit_in};

  always_comb begin
    hist_d = hist_q;
    if (clr) begin
      hist_d = '0;
    end else if (shift_en) begin
      hist_d = win[HIST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign eoemb_hit = (win == EOEMB_PAT);
  assign pilot_hit = (win[PILOT_W-1:0] == PILOT_PAT);

endmodule

// File: rtl/emb_sync_pos.sv
module emb_sync_pos
  import emb_sync_pkg::*;
#(
  parameter int E_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             step,
  input  logic [E_W-1:0]   emb_cnt,
  output logic [BLK_W-1:0] blk_q,
  output logic             mb_end_nx,
  output logic             emb_end_nx
);

  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_PER_MB - 1);

  logic [E_W-1:0]   last_mb;
  logic [E_W-1:0]   mb_q;
  logic [E_W-1:0]   mb_d;
  logic [E_W-1:0]   mb_nx;
  logic [BLK_W-1:0] blk_d;
  logic [BLK_W-1:0] blk_nx;

  // A count of zero behaves as one multiblock per extended multiblock.
  assign last_mb = (emb_cnt == '0) ? '0 : (emb_cnt - E_W'(1));

  // Position the next accepted block would take.
  assign blk_nx = blk_q + BLK_W'(1);

  always_comb begin
    mb_nx = mb_q;
    if (blk_q == BLK_LAST) begin
      mb_nx = (mb_q >= last_mb) ? '0 : (mb_q + E_W'(1));
    end
  end

  assign mb_end_nx  = (blk_nx == BLK_LAST);
  assign emb_end_nx = mb_end_nx && (mb_nx >= last_mb);

  always_comb begin
    blk_d = blk_q;
    mb_d  = mb_q;
    if (clr) begin
      blk_d = '0;
      mb_d  = '0;
    end else if (load) begin
      blk_d = BLK_LAST;
      mb_d  = last_mb;
    end else if (step) begin
      blk_d = blk_nx;
      mb_d  = mb_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
      mb_q  <= '0;
    end else begin
      blk_q <= blk_d;
      mb_q  <= mb_d;
    end
  end

endmodule

// File: rtl/emb_sync_fsm.sv
module emb_sync_fsm
  import emb_sync_pkg::*;
#(
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sh_lock,
  input  logic bit_vld,
  input  logic eoemb_hit,
  input  logic pilot_hit,
  input  logic mb_end_nx,
  input  logic emb_end_nx,
  output logic hist_clr,
  output logic hist_shift,
  output logic pos_clr,
  output logic pos_load,
  output logic pos_step,
  output logic lock_q,
  output logic eomb_q,
  output logic eoemb_q
);

  localparam int GOOD_W = $clog2(LOCK_CNT + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_CNT - 1);

  trk_state_t       st_q, st_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic             lock_d, eomb_d, eoemb_d;
  logic             chk_ok;

  assign hist_clr   = !sh_lock;
  assign hist_shift = sh_lock && bit_vld;
  assign chk_ok     = emb_end_nx ? eoemb_hit : pilot_hit;

  always_comb begin
    st_d     = st_q;
    good_d   = good_q;
    lock_d   = lock_q;
    eomb_d   = 1'b0;
    eoemb_d  = 1'b0;
    pos_clr  = 1'b0;
    pos_load = 1'b0;
    pos_step = 1'b0;
    if (!sh_lock) begin
      st_d    = TRK_HUNT;
      good_d  = '0;
      lock_d  = 1'b0;
      pos_clr = 1'b1;
    end else if (bit_vld) begin
      case (st_q)
        TRK_HUNT: begin
          if (eoemb_hit) begin
            st_d     = TRK_ALIGN;
            good_d   = GOOD_W'(1);
            pos_load = 1'b1;
            eomb_d   = 1'b1;
            eoemb_d  = 1'b1;
            if (LOCK_CNT <= 1) begin
              st_d   = TRK_LOCK;
              lock_d = 1'b1;
            end
          end
        end
        default: begin
          if (mb_end_nx && !chk_ok) begin
            st_d    = TRK_HUNT;
            good_d  = '0;
            lock_d  = 1'b0;
            pos_clr = 1'b1;
          end else begin
            pos_step = 1'b1;
            if (mb_end_nx) begin
              eomb_d  = 1'b1;
              eoemb_d = emb_end_nx;
              if (emb_end_nx && (st_q == TRK_ALIGN)) begin
                if (good_q >= GOOD_LAST) begin
                  st_d   = TRK_LOCK;
                  lock_d = 1'b1;
                end else begin
                  good_d = good_q + GOOD_W'(1);
                end
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TRK_HUNT;
      good_q  <= '0;
      lock_q  <= 1'b0;
      eomb_q  <= 1'b0;
      eoemb_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      good_q  <= good_d;
      lock_q  <= lock_d;
      eomb_q  <= eomb_d;
      eoemb_q <= eoemb_d;
    end
  end

endmodule

// File: rtl/emb_sync_tracker.sv
module emb_sync_tracker
  import emb_sync_pkg::*;
#(
  parameter int E_W      = 4,
  parameter int LOCK_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_lock,
  input  logic             bit_vld,
  input  logic             sync_bit,
  input  logic [E_W-1:0]   emb_count,
  output logic             emb_lock,
  output logic             eomb_stb,
  output logic             eoemb_stb,
  output logic [BLK_W-1:0] blk_idx
);

  logic eoemb_hit, pilot_hit;
  logic mb_end_nx, emb_end_nx;
  logic hist_clr, hist_shift;
  logic pos_clr, pos_load, pos_step;
  logic lock_q, eomb_q, eoemb_q;
  logic [BLK_W-1:0] blk_q;

  emb_sync_hist u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (hist_clr),
    .shift_en  (hist_shift),
    .bit_in    (sync_bit),
    .eoemb_hit (eoemb_hit),
    .pilot_hit (pilot_hit)
  );

  emb_sync_pos #(.E_W(E_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pos_clr),
    .load       (pos_load),
    .step       (pos_step),
    .emb_cnt    (emb_count),
    .blk_q      (blk_q),
    .mb_end_nx  (mb_end_nx),
    .emb_end_nx (emb_end_nx)
  );

  emb_sync_fsm #(.LOCK_CNT(LOCK_CNT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sh_lock    (sh_lock),
    .bit_vld    (bit_vld),
    .eoemb_hit  (eoemb_hit),
    .pilot_hit  (pilot_hit),
    .mb_end_nx  (mb_end_nx),
    .emb_end_nx (emb_end_nx),
    .hist_clr   (hist_clr),
    .hist_shift (hist_shift),
    .pos_clr    (pos_clr),
    .pos_load   (pos_load),
    .pos_step   (pos_step),
    .lock_q     (lock_q),
    .eomb_q     (eomb_q),
    .eoemb_q    (eoemb_q)
  );

  // Lock is withdrawn in the same cycle the header lock falls.
  assign emb_lock  = lock_q && sh_lock;
  assign eomb_stb  = eomb_q;
  assign eoemb_stb = eoemb_q;
  assign blk_idx   = blk_q;

endmodule

// File: rtl/emb_sync_tracker_chk.sv
module emb_sync_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sh_lock,
  input logic       bit_vld,
  input logic       emb_lock,
  input logic       eomb_stb,
  input logic       eoemb_stb,
  input logic [4:0] blk_idx
);

  a_r3_eomb_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    eomb_stb |-> (blk_idx == 5'd31));

  a_r4_eoemb_in_eomb: assert property (@(posedge clk) disable iff (!rst_n)
    eoemb_stb |-> eomb_stb);

  a_r7_lock_rise_at_emb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(emb_lock) |-> eoemb_stb);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> (!eomb_stb && !eoemb_stb));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && sh_lock) |=> $stable(blk_idx));

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_lock |=> ((blk_idx == 5'd0) && !eomb_stb && !eoemb_stb && !emb_lock));

  a_r3_step_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_lock && bit_vld && emb_lock) |=>
      ((blk_idx == 5'($past(blk_idx) + 5'd1)) || (blk_idx == 5'd0)));

endmodule

bind emb_sync_tracker emb_sync_tracker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sh_lock   (sh_lock),
  .bit_vld   (bit_vld),
  .emb_lock  (emb_lock),
  .eomb_stb  (eomb_stb),
  .eoemb_stb (eoemb_stb),
  .blk_idx   (blk_idx)
);

// File: tb/emb_sync_tracker_test.sv
module emb_sync_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int LOCK_N     = 4;
  localparam int WDOG_CYC   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sh_lock;
  logic       bit_vld;
  logic       sync_bit;
  logic [3:0] emb_count;
  logic       emb_lock;
  logic       eomb_stb;
  logic       eoemb_stb;
  logic [4:0] blk_idx;

  int n_cmp = 0;
  int n_bad = 0;

  // Stream position and positional reference state.
  int e_ref = 1;
  int tx_b = 0;
  int tx_m = 0;
  int run_len = 0;
  int ends = 0;
  bit aligned = 1'b0;
  int ex_blk = 0;
  int ex_eomb = 0;
  int ex_eoemb = 0;
  int ex_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emb_sync_tracker uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_lock   (sh_lock),
    .bit_vld   (bit_vld),
    .sync_bit  (sync_bit),
    .emb_count (emb_count),
    .emb_lock  (emb_lock),
    .eomb_stb  (eomb_stb),
    .eoemb_stb (eoemb_stb),
    .blk_idx   (blk_idx)
  );

  task automatic chk(input string tag, input string scen, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: got %0d expected %0d", tag, scen, what, act, exp);
    end
  endtask

  task automatic chk_all(input string scen);
    chk("R3", scen, "blk_idx",   int'(blk_idx),   ex_blk);
    chk("R3", scen, "eomb_stb",  int'(eomb_stb),  ex_eomb);
    chk("R4", scen, "eoemb_stb", int'(eoemb_stb), ex_eoemb);
    chk("R7", scen, "emb_lock",  int'(emb_lock),  ex_lock);
  endtask

  // ck: 0 clean, 1 flip pilot bit 28 of this multiblock, 2 clear the marker bit 26.
  task automatic send_bit(input int ck, input string scen);
    int  b;
    bit  emb_end, is_end, bad;
    logic v;
    b       = tx_b;
    emb_end = (tx_m == e_ref - 1);
    is_end  = (b == 31);
    if (b == 31)      v = 1'b1;
    else if (b >= 27) v = (ck == 1 && b == 28);
    else if (b == 26) v = (emb_end && ck != 2);
    else              v = ((b % 3) != 0);
    @(negedge clk);
    bit_vld  = 1'b1;
    sync_bit = v;
    @(posedge clk);
    #(CLK_PERIOD/4);
    run_len++;
    bad = (ck != 0);
    if (!aligned) begin
      if (is_end && emb_end && !bad && run_len >= 6) begin
        aligned = 1'b1; ends = 1;
        ex_blk = 31; ex_eomb = 1; ex_eoemb = 1;
      end else begin
        ex_blk = 0; ex_eomb = 0; ex_eoemb = 0;
      end
    end else if (is_end && bad) begin
      aligned = 1'b0; ends = 0;
      ex_blk = 0; ex_eomb = 0; ex_eoemb = 0;
    end else begin
      ex_blk   = b;
      ex_eomb  = is_end ? 1 : 0;
      ex_eoemb = (is_end && emb_end) ? 1 : 0;
      if (is_end && emb_end) ends++;
    end
    ex_lock = (aligned && ends >= LOCK_N) ? 1 : 0;
    chk_all(scen);
    tx_b++;
    if (tx_b == 32) begin
      tx_b = 0;
      tx_m = (tx_m + 1) % e_ref;
    end
  endtask

  task automatic idle_cycle(input string scen);
    @(negedge clk);
    bit_vld = 1'b0;
    @(posedge clk);
    #(CLK_PERIOD/4);
    ex_eomb = 0;
    ex_eoemb = 0;
    chk_all(scen);
  endtask

  // Drops header lock for one cycle (R9), then restarts with a new E and phase.
  task automatic start_run(input int e_in, input int b0, input int m0);
    @(negedge clk);
    sh_lock = 1'b0;
    bit_vld = 1'b0;
    #1;
    chk("R9", "lock drop", "emb_lock same cycle", int'(emb_lock), 0);
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk("R9", "lock drop", "blk_idx", int'(blk_idx), 0);
    chk("R9", "lock drop", "eomb_stb", int'(eomb_stb), 0);
    chk("R9", "lock drop", "eoemb_stb", int'(eoemb_stb), 0);
    chk("R9", "lock drop", "emb_lock", int'(emb_lock), 0);
    @(negedge clk);
    emb_count = 4'(e_in);
    e_ref   = (e_in == 0) ? 1 : e_in;
    tx_b    = b0;
    tx_m    = m0;
    aligned = 1'b0;
    ends    = 0;
    run_len = 0;
    ex_blk = 0; ex_eomb = 0; ex_eoemb = 0; ex_lock = 0;
    sh_lock = 1'b1;
  endtask

  task automatic run_to(input int m_target, input string scen);
    while (!(tx_b == 0 && tx_m == m_target)) send_bit(0, scen);
  endtask

  initial begin
    #(CLK_PERIOD * WDOG_CYC);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    sh_lock   = 1'b0;
    bit_vld   = 1'b0;
    sync_bit  = 1'b0;
    emb_count = 4'd1;
    repeat (3) @(negedge clk);
    chk("R1", "reset", "emb_lock",  int'(emb_lock),  0);
    chk("R1", "reset", "eomb_stb",  int'(eomb_stb),  0);
    chk("R1", "reset", "eoemb_stb", int'(eoemb_stb), 0);
    chk("R1", "reset", "blk_idx",   int'(blk_idx),   0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after reset", "blk_idx", int'(blk_idx), 0);
    sh_lock = 1'b1;

    // E = 1: hunt, align, lock.
    start_run(1, 10, 0);
    for (int i = 0; i < 32 * 6; i++) send_bit(0, "R2 hunt and lock E=1");
    chk("R7", "E=1 locked", "emb_lock", int'(emb_lock), 1);

    // E = 1: broken marker window at an extended multiblock end, then relock.
    run_to(0, "R6 pre");
    for (int i = 0; i < 32; i++) send_bit(1, "R6 broken end E=1");
    chk("R6", "E=1 loss", "emb_lock", int'(emb_lock), 0);
    chk("R6", "E=1 loss", "blk_idx", int'(blk_idx), 0);
    for (int i = 0; i < 32 * 5; i++) send_bit(0, "R6 relock E=1");

    // E = 3 with idle gaps, pilot loss in an inner multiblock, marker loss.
    start_run(3, 5, 1);
    for (int i = 0; i < 32 * 3 * 5; i++) begin
      send_bit(0, "R4 E=3");
      if ((i % 7) == 3) idle_cycle("R8 idle E=3");
    end
    chk("R7", "E=3 locked", "emb_lock", int'(emb_lock), 1);
    run_to(0, "R5 pre");
    for (int i = 0; i < 32; i++) send_bit(1, "R5 pilot loss E=3");
    chk("R5", "E=3 pilot loss", "emb_lock", int'(emb_lock), 0);
    for (int i = 0; i < 32 * 3 * 5; i++) send_bit(0, "R5 relock E=3");
    run_to(2, "R6 pre E=3");
    for (int i = 0; i < 32; i++) send_bit(2, "R6 marker loss E=3");
    chk("R6", "E=3 marker loss", "emb_lock", int'(emb_lock), 0);
    for (int i = 0; i < 32 * 3 * 5; i++) send_bit(0, "R6 relock E=3");

    // E = 2 starting mid stream.
    start_run(2, 20, 1);
    for (int i = 0; i < 32 * 2 * 6; i++) send_bit(0, "R4 E=2");

    // emb_count 0 acts as E = 1.
    start_run(0, 0, 0);
    for (int i = 0; i < 32 * 6; i++) begin
      send_bit(0, "R4 zero count");
      if ((i % 11) == 5) idle_cycle("R8 idle zero count");
    end
    chk("R7", "zero count locked", "emb_lock", int'(emb_lock), 1);

    // Final header lock drop while locked.
    start_run(1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule